// File: doc/BRIEF.md
# Self-Refresh Standby Sequencer

This block supervises a self-refreshing memory. It walks the part through its power-up initialisation and tracks which operating state the part is in: active, light standby, or deep standby. It also tells the refresh engine whether to run and which word address is the highest one it must keep. The inputs are the chip-select line, a standby-control level (high for normal use, low to request deep standby), two byte-lane enables and a 2-bit density code taken from a mode register. All waiting times are parameters counted in clock cycles.

The chip starts in a power-up state. The standby-control level must be held low for a minimum time. It is then raised, with chip select already high, and a longer window with both lines high follows before the memory is ready. In deep standby only a part of the array keeps its refresh, as chosen by the density code latched on entry. If the code selects no retention at all, the data is lost and leaving deep standby repeats the full initialisation window. An access made while the block is not ready is ignored and sets a sticky error flag.

Top module: `srf_standby_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, state_o is 0 (power-up), ready_o is 0, refresh_en_o is 0, refresh_top_o is 0 and proto_err_o is 0.
- R2: The block leaves power-up for the init window (state 1) only when stby_ctl rises after staying low for at least LOW_HOLD_CYC cycles and chip_sel_n is high in that same cycle. Otherwise it stays in state 0 and the low time must be counted again.
- R3: The init window ends after INIT_HOLD_CYC consecutive cycles with stby_ctl and chip_sel_n both high, and the block then moves to light standby (state 3). chip_sel_n low restarts the count. stby_ctl low returns the block to state 0.
- R4: When stby_ctl is high and the block is ready, state_o is 2 (active) if chip_sel_n is low and at least one lane enable is low. It is 3 (light standby) if chip_sel_n is high or both lane enables are high. The refresh range is then the full array, with refresh_top_o all ones.
- R5: stby_ctl low in state 2 or 3 moves the block to deep standby on the next edge. The density code is sampled on that edge, and later changes to dens_code have no effect until the next entry.
- R6: In deep standby with retention (state 4, or exit wait state 5), refresh_top_o is 0FFFFFh for code 00, 07FFFFh for code 01 and 03FFFFh for code 10, at the default 22-bit address width (full range shifted right by 2, 3 and 4).
- R7: stby_ctl high in state 4 starts the exit wait (state 5). After EXIT_HOLD_CYC cycles in state 5 the block returns to state 2 or 3. stby_ctl low during the wait sends it back to state 4.
- R8: Code 11 on entry gives state 6 (no retention) with refresh_en_o 0 and refresh_top_o 0. stby_ctl high then leads to state 1, and the full init window of R3 must be completed again.
- R9: ready_o is 1 only in states 2 and 3. It is 0 during power-up, the init window and every deep-standby state, including the exit wait.
- R10: An access (chip_sel_n low with at least one lane enable low) while ready_o is 0 sets proto_err_o. The flag stays set until reset, and apart from the restart in R3 the access does not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel_n | input | 1 | Chip select, active low |
| stby_ctl | input | 1 | Standby-control level: high for normal use, low requests deep standby |
| lane_lo_n | input | 1 | Lower byte-lane enable, active low |
| lane_hi_n | input | 1 | Upper byte-lane enable, active low |
| dens_code | input | 2 | Retention density code from the mode register |
| state_o | output | 3 | Current state: 0 power-up, 1 init, 2 active, 3 light standby, 4 deep hold, 5 exit wait, 6 no retention |
| ready_o | output | 1 | Normal use allowed |
| refresh_en_o | output | 1 | Refresh engine must run |
| refresh_top_o | output | ADDR_W | Highest word address to refresh |
| proto_err_o | output | 1 | Sticky flag for an access made while not ready |

## Verification
Every output comes from a single state register, so each result changes on the first clock edge after the input that causes it. The bench drives inputs on the falling edge and samples just after the next rising edge. Waits are counted in edges from the edge that enters the waiting state. The init window shows state 1 for exactly INIT_HOLD_CYC samples, and the exit wait shows state 5 for exactly EXIT_HOLD_CYC samples. The bench checks the last sample inside each window as well as the first one after it, so an off-by-one in either counter shows up as a mismatch.

// File: rtl/srf_pkg.sv
package srf_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP  = 3'd0,
        ST_INIT   = 3'd1,
        ST_ACTIVE = 3'd2,
        ST_STBY1  = 3'd3,
        ST_S2HOLD = 3'd4,
        ST_S2EXIT = 3'd5,
        ST_S2LOST = 3'd6
    } srf_state_e;

    localparam logic [1:0] DENS_NONE = 2'b11;

endpackage

// File: rtl/srf_seq.sv
module srf_seq
    import srf_pkg::*;
#(
    parameter int LOW_HOLD_CYC  = 10000,
    parameter int INIT_HOLD_CYC = 40000,
    parameter int EXIT_HOLD_CYC = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_sel_n,
    input  logic       stby_ctl,
    input  logic       lane_lo_n,
    input  logic       lane_hi_n,
    input  logic [1:0] dens_code,
    output srf_state_e state_o,
    output logic [1:0] dens_o,
    output logic       err_o
);

    localparam int MAX_A   = (LOW_HOLD_CYC > INIT_HOLD_CYC) ? LOW_HOLD_CYC : INIT_HOLD_CYC;
    localparam int MAX_CYC = (MAX_A > EXIT_HOLD_CYC) ? MAX_A : EXIT_HOLD_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] LOW_LIM  = CNT_W'(LOW_HOLD_CYC);
    localparam logic [CNT_W-1:0] INIT_END = CNT_W'(INIT_HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] EXIT_END = CNT_W'(EXIT_HOLD_CYC - 1);

    typedef struct packed {
        srf_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       dens;
        logic             err;
    } seq_t;

    seq_t       r_q, r_d;
    srf_state_e awake_st;
    logic       access;
    logic       is_ready;

    always_comb begin
        r_d      = r_q;
        access   = !chip_sel_n && !(lane_lo_n && lane_hi_n);
        awake_st = (chip_sel_n || (lane_lo_n && lane_hi_n)) ? ST_STBY1 : ST_ACTIVE;
        is_ready = (r_q.st == ST_ACTIVE) || (r_q.st == ST_STBY1);

        if (access && !is_ready) begin
            r_d.err = 1'b1;
        end

        case (r_q.st)
            ST_PWRUP: begin
                if (!stby_ctl) begin
                    if (r_q.cnt < LOW_LIM) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end else if ((r_q.cnt >= LOW_LIM) && chip_sel_n) begin
                    r_d.st  = ST_INIT;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = '0;
                end
            end
            ST_INIT: begin
                if (!stby_ctl) begin
                    r_d.st  = ST_PWRUP;
                    r_d.cnt = '0;
                end else if (!chip_sel_n) begin
                    r_d.cnt = '0;
                end else if (r_q.cnt == INIT_END) begin
                    r_d.st  = ST_STBY1;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_ACTIVE, ST_STBY1: begin
                if (!stby_ctl) begin
                    r_d.dens = dens_code;
                    r_d.cnt  = '0;
                    r_d.st   = (dens_code == DENS_NONE) ? ST_S2LOST : ST_S2HOLD;
                end else begin
                    r_d.st = awake_st;
                end
            end
            ST_S2HOLD: begin
                if (stby_ctl) begin
                    r_d.st  = ST_S2EXIT;
                    r_d.cnt = '0;
                end
            end
            ST_S2EXIT: begin
                if (!stby_ctl) begin
                    r_d.st  = ST_S2HOLD;
                    r_d.cnt = '0;
                end else if (r_q.cnt == EXIT_END) begin
                    r_d.st  = awake_st;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_S2LOST: begin
                if (stby_ctl) begin
                    r_d.st  = ST_INIT;
                    r_d.cnt = '0;
                end
            end
            default: begin
                r_d.st  = ST_PWRUP;
                r_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_PWRUP, cnt: '0, dens: 2'b00, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;
    assign dens_o  = r_q.dens;
    assign err_o   = r_q.err;

    // R2: the init window is only entered from power-up with chip select high
    a_r2_init_needs_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_INIT && $past(r_q.st) == ST_PWRUP) |-> $past(chip_sel_n));

    // R3: losing the control level during init falls back to power-up
    a_r3_init_drop_to_pwrup: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_INIT && !stby_ctl) |=> (r_q.st == ST_PWRUP));

    // R5: latched density does not move while held in deep standby
    a_r5_dens_held: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_S2HOLD) |=> $stable(r_q.dens));

    // R7: raising the control level in deep hold starts the exit wait
    a_r7_hold_to_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_S2HOLD && stby_ctl) |=> (r_q.st == ST_S2EXIT));

    // R10: the protocol error flag never clears without reset
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err |=> r_q.err);

endmodule

// File: rtl/srf_range_map.sv
module srf_range_map
    import srf_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  srf_state_e        state_i,
    input  logic [1:0]        dens_i,
    output logic              ren_o,
    output logic [ADDR_W-1:0] top_o
);

    localparam logic [ADDR_W-1:0] TOP_FULL = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] TOP_Q    = TOP_FULL >> 2;
    localparam logic [ADDR_W-1:0] TOP_E    = TOP_FULL >> 3;
    localparam logic [ADDR_W-1:0] TOP_S    = TOP_FULL >> 4;

    logic [ADDR_W-1:0] part_top;

    always_comb begin
        case (dens_i)
            2'b00:   part_top = TOP_Q;
            2'b01:   part_top = TOP_E;
            2'b10:   part_top = TOP_S;
            default: part_top = '0;
        endcase
    end

    always_comb begin
        case (state_i)
            ST_INIT, ST_ACTIVE, ST_STBY1: begin
                ren_o = 1'b1;
                top_o = TOP_FULL;
            end
            ST_S2HOLD, ST_S2EXIT: begin
                ren_o = 1'b1;
                top_o = part_top;
            end
            default: begin
                ren_o = 1'b0;
                top_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/srf_standby_ctrl.sv
module srf_standby_ctrl
    import srf_pkg::*;
#(
    parameter int ADDR_W        = 22,
    parameter int LOW_HOLD_CYC  = 10000,
    parameter int INIT_HOLD_CYC = 40000,
    parameter int EXIT_HOLD_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              stby_ctl,
    input  logic              lane_lo_n,
    input  logic              lane_hi_n,
    input  logic [1:0]        dens_code,
    output logic [2:0]        state_o,
    output logic              ready_o,
    output logic              refresh_en_o,
    output logic [ADDR_W-1:0] refresh_top_o,
    output logic              proto_err_o
);

    srf_state_e st;
    logic [1:0] dens_l;

    srf_seq #(
        .LOW_HOLD_CYC (LOW_HOLD_CYC),
        .INIT_HOLD_CYC(INIT_HOLD_CYC),
        .EXIT_HOLD_CYC(EXIT_HOLD_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_sel_n(chip_sel_n),
        .stby_ctl  (stby_ctl),
        .lane_lo_n (lane_lo_n),
        .lane_hi_n (lane_hi_n),
        .dens_code (dens_code),
        .state_o   (st),
        .dens_o    (dens_l),
        .err_o     (proto_err_o)
    );

    srf_range_map #(
        .ADDR_W(ADDR_W)
    ) u_map (
        .state_i(st),
        .dens_i (dens_l),
        .ren_o  (refresh_en_o),
        .top_o  (refresh_top_o)
    );

    assign state_o = st;
    assign ready_o = (st == ST_ACTIVE) || (st == ST_STBY1);

    // R8: nothing is refreshed once retention is given up
    a_r8_lost_refresh_off: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_S2LOST) |-> (!refresh_en_o && refresh_top_o == '0));

    // R9: the exit wait never reports ready
    a_r9_not_ready_in_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_S2EXIT) |-> !ready_o);

endmodule

// File: tb/tb_srf_standby_ctrl.sv
`timescale 1ns/1ps
module tb_srf_standby_ctrl;

    localparam int LOWC  = 4;
    localparam int INITC = 6;
    localparam int EXITC = 3;
    localparam logic [21:0] FULL = 22'h3FFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_sel_n = 1'b1;
    logic        stby_ctl = 1'b0;
    logic        lane_lo_n = 1'b1;
    logic        lane_hi_n = 1'b1;
    logic [1:0]  dens_code = 2'b00;
    logic [2:0]  state_o;
    logic        ready_o;
    logic        refresh_en_o;
    logic [21:0] refresh_top_o;
    logic        proto_err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    srf_standby_ctrl #(
        .ADDR_W(22), .LOW_HOLD_CYC(LOWC), .INIT_HOLD_CYC(INITC), .EXIT_HOLD_CYC(EXITC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .stby_ctl(stby_ctl),
        .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n), .dens_code(dens_code),
        .state_o(state_o), .ready_o(ready_o), .refresh_en_o(refresh_en_o),
        .refresh_top_o(refresh_top_o), .proto_err_o(proto_err_o)
    );

    typedef struct packed {
        logic        cs;
        logic        ctl;
        logic        lo;
        logic        hi;
        logic [1:0]  dens;
        logic [2:0]  st;
        logic        rdy;
        logic        ren;
        logic [21:0] top;
        logic        err;
        logic [3:0]  req;
    } tv_t;

    function automatic tv_t mk(input logic cs, input logic ctl, input logic lo, input logic hi,
                               input logic [1:0] dens, input logic [2:0] st, input logic rdy,
                               input logic ren, input logic [21:0] top, input logic [3:0] req);
        tv_t v;
        v = '{cs: cs, ctl: ctl, lo: lo, hi: hi, dens: dens, st: st, rdy: rdy,
              ren: ren, top: top, err: 1'b0, req: req};
        return v;
    endfunction

    localparam int NV = 33;
    // Starts from light standby (state 3) after initialisation.
    localparam tv_t TV [NV] = '{
        mk(1'b0,1'b1,1'b0,1'b0,2'd0,3'd2,1'b1,1'b1,FULL,4'd4),       // R4 both lanes
        mk(1'b0,1'b1,1'b1,1'b1,2'd0,3'd3,1'b1,1'b1,FULL,4'd4),       // R4 no lane
        mk(1'b0,1'b1,1'b0,1'b1,2'd0,3'd2,1'b1,1'b1,FULL,4'd4),       // R4 low lane
        mk(1'b0,1'b1,1'b1,1'b0,2'd0,3'd2,1'b1,1'b1,FULL,4'd4),       // R4 high lane
        mk(1'b1,1'b1,1'b0,1'b0,2'd0,3'd3,1'b1,1'b1,FULL,4'd4),       // R4 deselected
        mk(1'b1,1'b0,1'b1,1'b1,2'd1,3'd4,1'b0,1'b1,22'h07FFFF,4'd5), // R5 entry code 01
        mk(1'b1,1'b0,1'b1,1'b1,2'd3,3'd4,1'b0,1'b1,22'h07FFFF,4'd5), // R5 code change ignored
        mk(1'b1,1'b1,1'b1,1'b1,2'd3,3'd5,1'b0,1'b1,22'h07FFFF,4'd7), // R7 exit start
        mk(1'b1,1'b0,1'b1,1'b1,2'd3,3'd4,1'b0,1'b1,22'h07FFFF,4'd7), // R7 exit aborted
        mk(1'b1,1'b1,1'b1,1'b1,2'd3,3'd5,1'b0,1'b1,22'h07FFFF,4'd7),
        mk(1'b1,1'b1,1'b1,1'b1,2'd3,3'd5,1'b0,1'b1,22'h07FFFF,4'd7),
        mk(1'b1,1'b1,1'b1,1'b1,2'd3,3'd5,1'b0,1'b1,22'h07FFFF,4'd7), // R7 last wait cycle
        mk(1'b1,1'b1,1'b1,1'b1,2'd3,3'd3,1'b1,1'b1,FULL,4'd7),       // R7 back to normal
        mk(1'b1,1'b0,1'b1,1'b1,2'd0,3'd4,1'b0,1'b1,22'h0FFFFF,4'd6), // R6 code 00
        mk(1'b1,1'b1,1'b1,1'b1,2'd0,3'd5,1'b0,1'b1,22'h0FFFFF,4'd6),
        mk(1'b1,1'b1,1'b1,1'b1,2'd0,3'd5,1'b0,1'b1,22'h0FFFFF,4'd6),
        mk(1'b1,1'b1,1'b1,1'b1,2'd0,3'd5,1'b0,1'b1,22'h0FFFFF,4'd6),
        mk(1'b1,1'b1,1'b1,1'b1,2'd0,3'd3,1'b1,1'b1,FULL,4'd7),
        mk(1'b0,1'b1,1'b0,1'b0,2'd0,3'd2,1'b1,1'b1,FULL,4'd4),
        mk(1'b1,1'b0,1'b1,1'b1,2'd2,3'd4,1'b0,1'b1,22'h03FFFF,4'd6), // R6 code 10
        mk(1'b1,1'b1,1'b1,1'b1,2'd2,3'd5,1'b0,1'b1,22'h03FFFF,4'd6),
        mk(1'b1,1'b1,1'b1,1'b1,2'd2,3'd5,1'b0,1'b1,22'h03FFFF,4'd6),
        mk(1'b1,1'b1,1'b1,1'b1,2'd2,3'd5,1'b0,1'b1,22'h03FFFF,4'd6),
        mk(1'b1,1'b1,1'b1,1'b1,2'd2,3'd3,1'b1,1'b1,FULL,4'd7),
        mk(1'b1,1'b0,1'b1,1'b1,2'd3,3'd6,1'b0,1'b0,22'h0,4'd8),      // R8 no retention
        mk(1'b1,1'b0,1'b1,1'b1,2'd3,3'd6,1'b0,1'b0,22'h0,4'd8),
        mk(1'b1,1'b1,1'b1,1'b1,2'd3,3'd1,1'b0,1'b1,FULL,4'd8),       // R8 full re-init
        mk(1'b1,1'b1,1'b1,1'b1,2'd3,3'd1,1'b0,1'b1,FULL,4'd3),
        mk(1'b1,1'b1,1'b1,1'b1,2'd3,3'd1,1'b0,1'b1,FULL,4'd3),
        mk(1'b1,1'b1,1'b1,1'b1,2'd3,3'd1,1'b0,1'b1,FULL,4'd3),
        mk(1'b1,1'b1,1'b1,1'b1,2'd3,3'd1,1'b0,1'b1,FULL,4'd3),
        mk(1'b1,1'b1,1'b1,1'b1,2'd3,3'd1,1'b0,1'b1,FULL,4'd3),       // R3 last init cycle
        mk(1'b1,1'b1,1'b1,1'b1,2'd3,3'd3,1'b1,1'b1,FULL,4'd3)        // R3 window done
    };

    task automatic chk(input string req, input logic [2:0] st, input logic rdy, input logic ren,
                       input logic [21:0] top, input logic err);
        n_cmp++;
        if ({state_o, ready_o, refresh_en_o, refresh_top_o, proto_err_o} !== {st, rdy, ren, top, err}) begin
            n_bad++;
            $display("FAIL %s: got st=%0d rdy=%b ren=%b top=%h err=%b, expected st=%0d rdy=%b ren=%b top=%h err=%b",
                     req, state_o, ready_o, refresh_en_o, refresh_top_o, proto_err_o,
                     st, rdy, ren, top, err);
        end
    endtask

    task automatic cyc(input logic cs, input logic ctl, input logic lo, input logic hi, input logic [1:0] dens);
        @(negedge clk);
        chip_sel_n = cs; stby_ctl = ctl; lane_lo_n = lo; lane_hi_n = hi; dens_code = dens;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(5 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 in reset", 3'd0, 1'b0, 1'b0, 22'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 after release", 3'd0, 1'b0, 1'b0, 22'h0, 1'b0);

        // R2: low time too short
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'd0);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'd0);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 2'd0);
        chk("R2 short low", 3'd0, 1'b0, 1'b0, 22'h0, 1'b0);

        // R2: chip select low when the control level rises
        for (int i = 0; i < LOWC; i++) cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'd0);
        chk("R2 held low", 3'd0, 1'b0, 1'b0, 22'h0, 1'b0);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 2'd0);
        chk("R2 cs order", 3'd0, 1'b0, 1'b0, 22'h0, 1'b0);

        // R2 / R3: proper power-up
        for (int i = 0; i < LOWC; i++) cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'd0);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 2'd0);
        chk("R2 init entered", 3'd1, 1'b0, 1'b1, FULL, 1'b0);
        for (int i = 0; i < INITC - 1; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1, 2'd0);
        chk("R9 init not ready", 3'd1, 1'b0, 1'b1, FULL, 1'b0);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 2'd0);
        chk("R3 init done", 3'd3, 1'b1, 1'b1, FULL, 1'b0);

        for (int k = 0; k < NV; k++) begin
            cyc(TV[k].cs, TV[k].ctl, TV[k].lo, TV[k].hi, TV[k].dens);
            chk($sformatf("R%0d vector %0d", TV[k].req, k), TV[k].st, TV[k].rdy, TV[k].ren, TV[k].top, TV[k].err);
        end

        // R10: access during init is flagged and restarts the window (R3)
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'd3);
        chk("R8 lost again", 3'd6, 1'b0, 1'b0, 22'h0, 1'b0);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 2'd3);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 2'd3);
        chk("R10 access in init", 3'd1, 1'b0, 1'b1, FULL, 1'b1);
        for (int i = 0; i < INITC - 1; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1, 2'd3);
        chk("R3 restarted count", 3'd1, 1'b0, 1'b1, FULL, 1'b1);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 2'd3);
        chk("R10 sticky after ready", 3'd3, 1'b1, 1'b1, FULL, 1'b1);

        // R3: control level dropped during init
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'd3);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 2'd3);
        chk("R8 re-init entry", 3'd1, 1'b0, 1'b1, FULL, 1'b1);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'd3);
        chk("R3 drop to power-up", 3'd0, 1'b0, 1'b0, 22'h0, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule